// File: doc/BRIEF.md
# Two-Mode Burst Address Generator

This block produces the address for a four-beat burst into a synchronous memory with a 16-bit address. When an accepted start strobe arrives, the block captures the whole external address. The two low bits seed a 2-bit wraparound counter. Each asserted advance then steps the low two bits to the next beat. Bits 15..2 stay fixed until the next accepted start.

Two beat orderings are available. The interleaved order is the seed XOR a beat index. The linear order is the seed plus the beat index, modulo four. A parameter fixes one order at build time or hands the choice to a run-time input. The memory array and the data paths are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A start is accepted when `start` and `csel` are both 1 at a rising clock edge. From that edge on, `addr_out` equals the `addr_in` sampled at that edge, and the beat index returns to 0.
- R2: `start` has no effect when `csel` is 0 at the edge. The address is kept, or it advances if `adv` is 1.
- R3: In interleaved order (`lin_mode` = 0 at run time), the low two bits equal the seed XOR the beat index. Seed 00 gives 00,01,10,11; seed 01 gives 01,00,11,10; seed 10 gives 10,11,00,01; seed 11 gives 11,10,01,00.
- R4: In linear order (`lin_mode` = 1 at run time), the low two bits equal the seed plus the beat index, modulo 4. For example, seed 10 gives 10,11,00,01.
- R5: If `adv` is 1 at an edge and no start is accepted, the beat index steps by one.
- R6: When a start is accepted, `adv` is ignored in that cycle. The new external address appears unstepped.
- R7: If there is no accepted start and `adv` is 0, `addr_out` holds its previous value.
- R8: `addr_out[15:2]` changes only on an accepted start. A wrap of the low bits never carries into bit 2.
- R9: Advancing past the fourth beat wraps the sequence back to the first address. There is no stop and no flag.
- R10: A synchronous active-low reset clears the captured address and the beat index, so `addr_out` reads 0 after the edge.
- R11: The `ORDER` parameter selects the ordering: 0 fixes interleaved, 1 fixes linear, and 2 (the default) follows `lin_mode`. In mode 2 the output follows `lin_mode` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Burst start strobe |
| csel | input | 1 | Chip select that qualifies `start` |
| adv | input | 1 | Step to the next beat |
| lin_mode | input | 1 | 1 selects linear order, 0 selects interleaved order (used when ORDER=2) |
| addr_in | input | 16 | External address |
| addr_out | output | 16 | Current burst address |

## Verification
The bench walks bursts from every kind of seed in both orders. A design that used linear stepping for the interleaved order would give 10 instead of 00 as the second beat from seed 01. A design that let the wrap carry out would bump bit 2 when the linear order rolls from 11 to 00.

The bench also applies a start together with `adv`; a design that let the advance win would show the stepped address. A start with chip select low must leave the captured address alone but still allow an advance.

A reset in the middle of a burst must also clear the beat index. Otherwise the next advance would land on the wrong beat. Flipping `lin_mode` with the state held shows whether the order selection reaches the output.

// File: rtl/bam_pkg.sv
// Shared types for the burst address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package bam_pkg;

    // Selects how the beat order is chosen
    typedef enum logic [1:0] {
        ORD_INTERLEAVED = 2'd0,
        ORD_LINEAR      = 2'd1,
        ORD_RUNTIME     = 2'd2
    } order_sel_e;

endpackage

// File: rtl/bam_base_reg.sv
// Holds the upper address bits and the low-bit seed captured at burst start.
// Assumes: load is already qualified by chip select.
module bam_base_reg #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:CNT_W] upper,
    output logic [CNT_W-1:0]  seed
);

    // Capture the address on an accepted start; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper <= '0;
            seed  <= '0;
        end else if (load) begin
            upper <= addr_in[ADDR_W-1:CNT_W];
            seed  <= addr_in[CNT_W-1:0];
        end
    end

    // R8: the upper bits move only when a load happens
    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(upper));

endmodule

// File: rtl/bam_beat_ctr.sv
// Beat index of the current burst: cleared on load, stepped on advance, wraps freely.
// Assumes: load takes priority over adv.
module bam_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [CNT_W-1:0] beat
);

    // Restart at beat 0 on load, otherwise step on advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else if (load)
            beat <= '0;
        else if (adv)
            beat <= beat + 1'b1;
    end

    // R5: an advance without a load moves the index by exactly one
    assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> beat == CNT_W'($past(beat) + 1'b1));

    // R6: a load restarts the index whatever adv was
    assert_load_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> beat == '0);

endmodule

// File: rtl/bam_order_map.sv
// Maps the seed and beat index to the low address bits in the chosen order.
// Assumes: purely combinational; ORDER picks a fixed order or the lin_mode input.
module bam_order_map
    import bam_pkg::*;
#(
    parameter order_sel_e ORDER = ORD_RUNTIME,
    parameter int         CNT_W = 2
) (
    input  logic             lin_mode,
    input  logic [CNT_W-1:0] seed,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] low
);

    logic [CNT_W-1:0] ilv_low;
    logic [CNT_W-1:0] lin_low;

    // Both candidate orders; the adder drops its carry so the field wraps
    always_comb begin
        ilv_low = seed ^ beat;
        lin_low = seed + beat;
    end

    generate
        if (ORDER == ORD_INTERLEAVED) begin : g_ilv
            logic unused_mode;
            logic [CNT_W-1:0] unused_lin;
            assign unused_mode = lin_mode;
            assign unused_lin  = lin_low;
            assign low = ilv_low;
        end else if (ORDER == ORD_LINEAR) begin : g_lin
            logic unused_mode;
            logic [CNT_W-1:0] unused_ilv;
            assign unused_mode = lin_mode;
            assign unused_ilv  = ilv_low;
            assign low = lin_low;
        end else begin : g_rt
            assign low = lin_mode ? lin_low : ilv_low;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
// Top of the burst address generator: captures a start address, then steps the
// low two bits through a four-beat wraparound burst in interleaved or linear order.
// Assumes: start is honoured only with csel high; start wins over adv.
module burst_addr_gen
    import bam_pkg::*;
#(
    parameter int         ADDR_W = 16,
    parameter int         CNT_W  = 2,
    parameter order_sel_e ORDER  = ORD_RUNTIME
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              csel,
    input  logic              adv,
    input  logic              lin_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    logic                    load;
    logic [ADDR_W-1:CNT_W]   upper;
    logic [CNT_W-1:0]        seed;
    logic [CNT_W-1:0]        beat;
    logic [CNT_W-1:0]        low;

    // Qualify the start strobe with chip select
    always_comb load = start & csel;

    bam_base_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_in),
        .upper   (upper),
        .seed    (seed)
    );

    bam_beat_ctr #(.CNT_W(CNT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .beat  (beat)
    );

    bam_order_map #(.ORDER(ORDER), .CNT_W(CNT_W)) u_map (
        .lin_mode (lin_mode),
        .seed     (seed),
        .beat     (beat),
        .low      (low)
    );

    // Assemble the output address
    always_comb addr_out = {upper, low};

    // R1: after an accepted start the output shows the captured address
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_out == $past(addr_in));

    // R7: with no start and no advance the address holds unless the order input moved
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(addr_out) || !$stable(lin_mode)));

    // R10: a reset cycle leaves the output at zero
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> addr_out == '0);

endmodule

// File: tb/burst_addr_gen_tb.sv
// Self-checking bench for burst_addr_gen (ORDER = run-time select).
module burst_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_N      = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        csel = 1'b0;
    logic        adv = 1'b0;
    logic        lin_mode = 1'b0;
    logic [15:0] addr_in = '0;
    logic [15:0] addr_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .csel     (csel),
        .adv      (adv),
        .lin_mode (lin_mode),
        .addr_in  (addr_in),
        .addr_out (addr_out)
    );

    // Each vector: {start, csel, adv, lin_mode, addr_in[15:0], expected[15:0]}
    localparam logic [35:0] VEC [VEC_N] = '{
        {4'b1100, 16'hABCD, 16'hABCD},  // start, seed 01 interleaved
        {4'b0010, 16'h0000, 16'hABCC},  // beat 1: 00
        {4'b0010, 16'h0000, 16'hABCF},  // beat 2: 11
        {4'b0010, 16'h0000, 16'hABCE},  // beat 3: 10
        {4'b0010, 16'h0000, 16'hABCD},  // wrap to first
        {4'b0000, 16'h5555, 16'hABCD},  // hold
        {4'b1000, 16'h1234, 16'hABCD},  // start, chip select low
        {4'b1111, 16'h1236, 16'h1236},  // start with adv, linear
        {4'b0011, 16'h0000, 16'h1237},  // linear 11
        {4'b0011, 16'h0000, 16'h1234},  // linear 00, no carry
        {4'b0011, 16'h0000, 16'h1235},  // linear 01
        {4'b0011, 16'h0000, 16'h1236},  // wrap to first
        {4'b1011, 16'hFFFF, 16'h1237},  // deselected start still advances
        {4'b1100, 16'h8003, 16'h8003},  // start, seed 11 interleaved
        {4'b0010, 16'h0000, 16'h8002},
        {4'b0010, 16'h0000, 16'h8001},
        {4'b0010, 16'h0000, 16'h8000},
        {4'b1100, 16'h0000, 16'h0000},  // start, seed 00
        {4'b0010, 16'h0000, 16'h0001},
        {4'b0010, 16'h0000, 16'h0002},
        {4'b0010, 16'h0000, 16'h0003}
    };

    string vec_tag [VEC_N] = '{
        "R1", "R3", "R3", "R3", "R9", "R7", "R2", "R6", "R4", "R8", "R4",
        "R9", "R2", "R1", "R3", "R3", "R3", "R1", "R3", "R3", "R3"
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: addr_out=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state
        tick();
        tick();
        check("R10", addr_out, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < VEC_N; i++) begin
            {start, csel, adv, lin_mode} = VEC[i][35:32];
            addr_in = VEC[i][31:16];
            tick();
            check(vec_tag[i], addr_out, VEC[i][15:0]);
        end

        // R10: reset in the middle of a burst clears address and beat index
        start = 1'b1; csel = 1'b1; adv = 1'b0; lin_mode = 1'b0; addr_in = 16'h7E02;
        tick();
        start = 1'b0; adv = 1'b1;
        tick();
        rst_n = 1'b0;
        tick();
        check("R10", addr_out, 16'h0000);
        rst_n = 1'b1;
        tick();
        check("R10", addr_out, 16'h0001);

        // R11: in run-time mode the order follows lin_mode without a clock
        start = 1'b1; adv = 1'b0; addr_in = 16'h4001;
        tick();
        start = 1'b0; adv = 1'b1;
        tick();
        adv = 1'b0;
        check("R11", addr_out, 16'h4000);
        lin_mode = 1'b1;
        #1;
        check("R11", addr_out, 16'h4002);

        // R3: seed 10 in interleaved order
        lin_mode = 1'b0; start = 1'b1; addr_in = 16'h2222;
        tick();
        start = 1'b0; adv = 1'b1;
        tick();
        check("R3", addr_out, 16'h2223);
        tick();
        check("R3", addr_out, 16'h2220);

        finish_run();
    end

endmodule